// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading a two-level page table from memory. A request carries the virtual address and an access kind (read, write or execute). A base register gives the byte address of the first-level table. The block holds one request at a time. It first fetches the first-level entry, which points at a second-level table. It then fetches the second-level entry, which holds the frame number, the state bits and the permission code.

The block checks the final entry for validity and for the permission of the requested access. When an access is allowed it sets the referenced bit and, for a write, the modified bit. The updated word is stored back to memory only if one of those bits actually changes. The caller sees a one-cycle `done` pulse that carries a 2-bit status and, on success, the physical address. The field widths are parameters: first-level index, second-level index, page offset and frame number. The defaults are 12/8/12/20 for 4 KB pages.

Every table entry is a `DATA_W`-bit word. Counting from bit 0 upward it holds the frame number (`PFN_W` bits), the 2-bit permission code, the modified bit, the referenced bit and the valid bit. The valid bit sits at position `PFN_W+4`.

Top module: `pt_walker`

## Requirements
- R1: On an accepted request the first memory read goes to `root_base + first_index*4`, where first_index is the top `MIDX_W` bits of the virtual address. `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`.
- R2: If the first-level entry has its valid bit set, the second read goes to `(entry frame << OFF_W) + second_index*4`, where second_index is the next `SIDX_W` bits. If the valid bit is clear, the walk ends with status 01 after that single read.
- R3: If the second-level entry has its valid bit clear, the status is 01 (not valid). Every faulting result returns a physical address of 0.
- R4: Access codes are 00 read, 01 write, 10 execute and 11 reserved. Permission codes are 00 none, 01 read only, 10 read/write and 11 execute only. An access the code forbids on a valid entry gives status 10 and no memory write. Status 11 is never produced.
- R5: A successful walk gives status 00 and a physical address made of the entry frame number above the unchanged `OFF_W`-bit page offset. For example, offset 0x678 with frame 0x01000 gives 0x01000678.
- R6: A permitted read sets the referenced bit. A permitted write sets both the referenced and modified bits. A permitted execute leaves the entry unchanged. All other entry bits are preserved.
- R7: The updated entry is written to the same address it was read from, and only when its value differs from the value read. `done` follows the write acknowledge.
- R8: `busy` is high from the accepting edge until the edge that raises `done`. `done` lasts one cycle. `req_valid` is ignored while busy. No memory request is issued while idle.
- R9: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation (taken when idle) |
| req_vaddr | input | MIDX_W+SIDX_W+OFF_W | Virtual address |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| root_base | input | PFN_W+OFF_W | Byte address of the first-level table |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle result strobe |
| rsp_status | output | 2 | 00 ok, 01 not valid, 10 protection |
| rsp_paddr | output | PFN_W+OFF_W | Physical address (0 on a fault) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | PFN_W+OFF_W | Byte address of the word |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Request completed (read data valid this cycle) |
| mem_rdata | input | DATA_W | Read data |

## Verification
The bench builds the walker with 3-bit indices, an 8-bit offset and a 10-bit frame number. This keeps the tables small enough to hold in a sparse bench memory while every index value is still reached. With those widths a sweep covers every combination of entry valid, referenced, modified, permission code and access kind. Each point of the sweep checks the read address sequence, the write-back decision and word, the status and the physical address. Memory latency rotates between zero and two wait cycles, and separate cases cover an invalid first-level entry and a request raised while busy.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_EXEC  = 2'b10;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RO   = 2'b01;
  localparam logic [1:0] PERM_RW   = 2'b10;
  localparam logic [1:0] PERM_XO   = 2'b11;

  typedef enum logic [1:0] {
    WS_OK       = 2'b00,
    WS_NOTVALID = 2'b01,
    WS_PROT     = 2'b10
  } walk_status_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_MST  = 2'd1,
    S_SEC  = 2'd2,
    S_WB   = 2'd3
  } walk_state_e;

  // Permission decision: one allowed access kind set per permission code.
  function automatic logic perm_allows(input logic [1:0] perm, input logic [1:0] acc);
    logic ok;
    unique case (perm)
      PERM_RO: ok = (acc == ACC_READ);
      PERM_RW: ok = (acc == ACC_READ) || (acc == ACC_WRITE);
      PERM_XO: ok = (acc == ACC_EXEC);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Whether an allowed access marks the entry as referenced / modified.
  function automatic logic acc_marks_ref(input logic [1:0] acc);
    return (acc == ACC_READ) || (acc == ACC_WRITE);
  endfunction

  function automatic logic acc_marks_mod(input logic [1:0] acc);
    return (acc == ACC_WRITE);
  endfunction

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int MIDX_W = 12,
  parameter int SIDX_W = 8,
  parameter int OFF_W  = 12,
  parameter int PFN_W  = 20,
  localparam int VA_W  = MIDX_W + SIDX_W + OFF_W,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PA_W-1:0]  root_base,
  input  logic [PFN_W-1:0] tbl_frame,
  output logic [PA_W-1:0]  mst_addr,
  output logic [PA_W-1:0]  sec_addr,
  output logic [OFF_W-1:0] page_off
);
  localparam int MSCALE_W = MIDX_W + 2;
  localparam int SSCALE_W = SIDX_W + 2;

  logic [MIDX_W-1:0] midx;
  logic [SIDX_W-1:0] sidx;
  logic [MSCALE_W-1:0] midx_bytes;
  logic [SSCALE_W-1:0] sidx_bytes;

  assign midx     = vaddr[VA_W-1 -: MIDX_W];
  assign sidx     = vaddr[OFF_W +: SIDX_W];
  assign page_off = vaddr[OFF_W-1:0];

  assign midx_bytes = {midx, 2'b00};
  assign sidx_bytes = {sidx, 2'b00};

  assign mst_addr = root_base + PA_W'(midx_bytes);
  assign sec_addr = {tbl_frame, {OFF_W{1'b0}}} + PA_W'(sidx_bytes);
endmodule

// File: rtl/pt_pte_eval.sv
module pt_pte_eval
  import pt_walk_pkg::*;
#(
  parameter int PFN_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] pte,
  input  logic [1:0]        acc,
  output logic              pte_valid,
  output logic              allowed,
  output logic [DATA_W-1:0] pte_next,
  output logic              pte_changed,
  output logic [PFN_W-1:0]  pfn
);
  localparam int B_PERM  = PFN_W;
  localparam int B_MOD   = PFN_W + 2;
  localparam int B_REF   = PFN_W + 3;
  localparam int B_VALID = PFN_W + 4;

  logic [1:0] perm;

  assign pfn       = pte[PFN_W-1:0];
  assign perm      = pte[B_PERM +: 2];
  assign pte_valid = pte[B_VALID];
  assign allowed   = perm_allows(perm, acc);

  always_comb begin
    pte_next = pte;
    if (acc_marks_ref(acc)) pte_next[B_REF] = 1'b1;
    if (acc_marks_mod(acc)) pte_next[B_MOD] = 1'b1;
  end

  assign pte_changed = (pte_next != pte);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int MIDX_W = 12,
  parameter int SIDX_W = 8,
  parameter int OFF_W  = 12,
  parameter int PFN_W  = 20,
  parameter int DATA_W = 32,
  localparam int VA_W  = MIDX_W + SIDX_W + OFF_W,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic [PA_W-1:0]   root_base,
  output logic              busy,
  output logic              done,
  output logic [1:0]        rsp_status,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int B_VALID = PFN_W + 4;

  walk_state_e state;
  logic [VA_W-1:0]  vaddr_q;
  logic [1:0]       acc_q;

  logic [VA_W-1:0]  va_sel;
  logic [PA_W-1:0]  mst_addr;
  logic [PA_W-1:0]  sec_addr;
  logic [OFF_W-1:0] page_off;

  logic              pte_valid;
  logic              allowed;
  logic [DATA_W-1:0] pte_next;
  logic              pte_changed;
  logic [PFN_W-1:0]  pfn;

  // Named events for the checker.
  logic ev_accept;
  logic ev_mst_fault;
  logic ev_sec_fault;
  logic ev_prot_fault;
  logic ev_writeback;
  logic ev_finish_ok;

  assign va_sel = (state == S_IDLE) ? req_vaddr : vaddr_q;

  pt_va_split #(
    .MIDX_W(MIDX_W), .SIDX_W(SIDX_W), .OFF_W(OFF_W), .PFN_W(PFN_W)
  ) u_split (
    .vaddr     (va_sel),
    .root_base (root_base),
    .tbl_frame (mem_rdata[PFN_W-1:0]),
    .mst_addr  (mst_addr),
    .sec_addr  (sec_addr),
    .page_off  (page_off)
  );

  pt_pte_eval #(
    .PFN_W(PFN_W), .DATA_W(DATA_W)
  ) u_eval (
    .pte         (mem_rdata),
    .acc         (acc_q),
    .pte_valid   (pte_valid),
    .allowed     (allowed),
    .pte_next    (pte_next),
    .pte_changed (pte_changed),
    .pfn         (pfn)
  );

  assign ev_accept     = (state == S_IDLE) && req_valid;
  assign ev_mst_fault  = (state == S_MST) && mem_ack && !mem_rdata[B_VALID];
  assign ev_sec_fault  = (state == S_SEC) && mem_ack && !pte_valid;
  assign ev_prot_fault = (state == S_SEC) && mem_ack && pte_valid && !allowed;
  assign ev_writeback  = (state == S_SEC) && mem_ack && pte_valid && allowed && pte_changed;
  assign ev_finish_ok  = ((state == S_SEC) && mem_ack && pte_valid && allowed && !pte_changed)
                       || ((state == S_WB) && mem_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      vaddr_q    <= '0;
      acc_q      <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      rsp_status <= WS_OK;
      rsp_paddr  <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            vaddr_q  <= req_vaddr;
            acc_q    <= req_acc;
            busy     <= 1'b1;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= mst_addr;
            state    <= S_MST;
          end
        end
        S_MST: begin
          if (mem_ack) begin
            if (!mem_rdata[B_VALID]) begin
              mem_req    <= 1'b0;
              busy       <= 1'b0;
              done       <= 1'b1;
              rsp_status <= WS_NOTVALID;
              rsp_paddr  <= '0;
              state      <= S_IDLE;
            end else begin
              mem_addr <= sec_addr;
              state    <= S_SEC;
            end
          end
        end
        S_SEC: begin
          if (mem_ack) begin
            if (!pte_valid || !allowed) begin
              mem_req    <= 1'b0;
              busy       <= 1'b0;
              done       <= 1'b1;
              rsp_status <= pte_valid ? WS_PROT : WS_NOTVALID;
              rsp_paddr  <= '0;
              state      <= S_IDLE;
            end else if (pte_changed) begin
              mem_we    <= 1'b1;
              mem_wdata <= pte_next;
              rsp_paddr <= {pfn, page_off};
              state     <= S_WB;
            end else begin
              mem_req    <= 1'b0;
              busy       <= 1'b0;
              done       <= 1'b1;
              rsp_status <= WS_OK;
              rsp_paddr  <= {pfn, page_off};
              state      <= S_IDLE;
            end
          end
        end
        S_WB: begin
          if (mem_ack) begin
            mem_req    <= 1'b0;
            mem_we     <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b1;
            rsp_status <= WS_OK;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PFN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [1:0]        rsp_status,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [PA_W-1:0]   mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              ev_prot_fault,
  input logic              ev_writeback
);
  localparam int B_REF   = PFN_W + 3;
  localparam int B_VALID = PFN_W + 4;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R1

  AST_FAULT_ZERO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_status != 2'b00) |-> (rsp_paddr == '0)); // R3

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rsp_status != 2'b11)); // R4

  AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prot_fault |=> !mem_req); // R4

  AST_WB_MARKS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[B_REF] && mem_wdata[B_VALID])); // R6

  AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_writeback |=> (mem_we && $stable(mem_addr))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R8
endmodule

bind pt_walker pt_walker_chk #(
  .PFN_W(PFN_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .rsp_status    (rsp_status),
  .rsp_paddr     (rsp_paddr),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .mem_ack       (mem_ack),
  .ev_prot_fault (ev_prot_fault),
  .ev_writeback  (ev_writeback)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int MIDX_W = 3;
  localparam int SIDX_W = 3;
  localparam int OFF_W  = 8;
  localparam int PFN_W  = 10;
  localparam int DATA_W = 32;
  localparam int VA_W   = MIDX_W + SIDX_W + OFF_W;
  localparam int PA_W   = PFN_W + OFF_W;
  localparam int ROOT   = 'h100;
  localparam int TBASE  = 'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] req_acc = '0;
  logic [PA_W-1:0] root_base = PA_W'(ROOT);
  logic busy, done, mem_req, mem_we;
  logic [1:0] rsp_status;
  logic [PA_W-1:0] rsp_paddr, mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pt_walker #(
    .MIDX_W(MIDX_W), .SIDX_W(SIDX_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .DATA_W(DATA_W)
  ) i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .root_base(root_base), .busy(busy), .done(done),
    .rsp_status(rsp_status), .rsp_paddr(rsp_paddr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Sparse memory model with rotating latency and an access log.
  logic [DATA_W-1:0] mem [int unsigned];
  int n_rd = 0;
  int n_wr = 0;
  int rd_addr [8];
  int wr_addr = 0;
  int lat = 0;
  int lat_seed = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (lat == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[int'(mem_addr) / 4] = mem_wdata;
          wr_addr <= int'(mem_addr);
          n_wr <= n_wr + 1;
        end else begin
          mem_rdata <= mem.exists(int'(mem_addr) / 4) ? mem[int'(mem_addr) / 4] : '0;
          rd_addr[n_rd % 8] <= int'(mem_addr);
          n_rd <= n_rd + 1;
        end
        lat_seed <= lat_seed + 1;
        lat <= (lat_seed + 1) % 3;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int mk_entry(input int v, input int r, input int m, input int perm, input int frame);
    return v * (1 << (PFN_W + 4)) + r * (1 << (PFN_W + 3)) + m * (1 << (PFN_W + 2))
         + perm * (1 << PFN_W) + frame;
  endfunction

  // Runs one walk; returns after done has been sampled.
  task automatic walk(input int va, input int acc);
    int guard;
    @(negedge clk);
    req_vaddr = VA_W'(va);
    req_acc   = 2'(acc);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "busy", busy, 0);
    check("R9", "done", done, 0);
    check("R9", "mem_req", mem_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8", "idle mem_req", mem_req, 0);

    // Invalid first-level entry for each access kind (R2).
    for (int a = 0; a < 3; a++) begin
      int midx, va, rd0;
      midx = 5;
      mem[(ROOT + midx * 4) / 4] = DATA_W'(mk_entry(0, 0, 0, 2, TBASE + midx));
      va = (midx << (SIDX_W + OFF_W)) | (2 << OFF_W) | 8'h3c;
      rd0 = n_rd;
      walk(va, a);
      check("R2", "master invalid status", rsp_status, 1);
      check("R2", "master invalid reads", n_rd - rd0, 1);
      check("R3", "fault paddr", rsp_paddr, 0);
    end

    // Full sweep over entry bits, permission code and access kind.
    for (int n = 0; n < 96; n++) begin
      int acc, perm, m, r, v, midx, sidx, off, frame, va, pte, sa;
      int rd0, wr0, ok, exp_pte, exp_status;
      acc = n % 3; perm = (n / 3) % 4; m = (n / 12) % 2; r = (n / 24) % 2; v = (n / 48) % 2;
      midx = n % 8; sidx = (n / 8) % 8; off = (n * 37) % 256; frame = (n * 13 + 5) % 1024;
      mem[(ROOT + midx * 4) / 4] = DATA_W'(mk_entry(1, 0, 0, 0, TBASE + midx));
      sa = ((TBASE + midx) << OFF_W) + sidx * 4;
      pte = mk_entry(v, r, m, perm, frame);
      mem[sa / 4] = DATA_W'(pte);
      va = (midx << (SIDX_W + OFF_W)) + (sidx << OFF_W) + off;
      rd0 = n_rd; wr0 = n_wr;
      walk(va, acc);
      // expected permission by table: RO->read, RW->read/write, XO->exec
      case (perm)
        1: ok = (acc == 0);
        2: ok = (acc <= 1);
        3: ok = (acc == 2);
        default: ok = 0;
      endcase
      exp_status = (v == 0) ? 1 : (ok ? 0 : 2);
      exp_pte = pte;
      if (exp_status == 0 && acc != 2) exp_pte = mk_entry(1, 1, (acc == 1) ? 1 : m, perm, frame);
      check("R1", "first read addr", rd_addr[rd0 % 8], ROOT + midx * 4);
      check("R2", "second read addr", rd_addr[(rd0 + 1) % 8], sa);
      check("R4", "status", rsp_status, exp_status);
      if (exp_status == 0) check("R5", "paddr", rsp_paddr, (frame << OFF_W) + off);
      else check("R3", "fault paddr", rsp_paddr, 0);
      check("R6", "entry after walk", mem[sa / 4], exp_pte);
      check("R7", "write count", n_wr - wr0, (exp_pte != pte) ? 1 : 0);
      if (exp_pte != pte) check("R7", "write addr", wr_addr, sa);
    end

    // R8: request held while busy is ignored.
    begin
      int sa;
      mem[(ROOT + 4) / 4] = DATA_W'(mk_entry(1, 0, 0, 0, TBASE + 1));
      sa = ((TBASE + 1) << OFF_W) + 3 * 4;
      mem[sa / 4] = DATA_W'(mk_entry(1, 1, 1, 2, 'h155));
      @(negedge clk);
      req_vaddr = VA_W'((1 << (SIDX_W + OFF_W)) + (3 << OFF_W) + 'h21);
      req_acc = 2'b00; req_valid = 1'b1;
      @(negedge clk);
      check("R8", "busy after accept", busy, 1);
      req_vaddr = VA_W'((6 << (SIDX_W + OFF_W)) + 'h77);
      req_acc = 2'b10;
      @(negedge clk);
      req_valid = 1'b0;
      for (int g = 0; g < 100 && !done; g++) @(negedge clk);
      check("R8", "done seen", done, 1);
      check("R8", "busy at done", busy, 0);
      check("R8", "first request kept", rsp_paddr, ('h155 << OFF_W) + 'h21);
      @(negedge clk);
      check("R8", "done one cycle", done, 0);
      check("R8", "stays idle", busy, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule